// File: doc/BRIEF.md
# Alarm Compare Interrupt Controller

This block watches a 48-bit seconds count and raises a level-high interrupt when the count reaches a programmed alarm time. The count comes from outside and advances in a slow timekeeping domain. That domain is modelled here as a single-cycle `slow_tick` strobe in the bus clock. All slow-domain state changes only on cycles where the strobe is high.

Software talks to the block through a simple register port. The port has a write strobe, and a read strobe that returns data one cycle later with `rvalid`. The alarm time is split into a 32-bit low word and a 16-bit high word. There are two event bits:

- Event 0 (primary) records the count arriving at the alarm value.
- Event 1 (alternate) records the count moving away from it.

Each event bit has an enable. Enables are turned on through one register and off through another, and writing a zero bit to either register leaves that enable unchanged. Status bits are cleared by writing 1.

Bus writes are staged and only reach the slow domain at the next tick. A two-bit pending field shows that a transfer is still waiting. The bus-visible copy of the raw status picks up new events by itself. A clear becomes visible there only after an explicit reload request.

Register offsets (byte addresses on `addr`):

| Offset | Contents |
|---|---|
| 0x00 | Alarm low word |
| 0x04 | Alarm high word |
| 0x08 | Raw status |
| 0x0C | Masked status, write 1 to clear |
| 0x10 | Enable set |
| 0x14 | Enable clear |
| 0x18 | Sync pending (read) and reload request (write bit 31) |

Top module: `alarm_cmp_irq_ctrl`

## Requirements
- R1: After reset the alarm reads all ones (low word 0xFFFFFFFF, high word 0x0000FFFF). Enables, raw status, masked status and the pending field all read 0, and `irq` is 0.
- R2: A write to 0x00 sets alarm bits 31:0 and a write to 0x04 sets alarm bits 47:32 from wdata[15:0]. The upper bits of the high word read as 0. The compare covers all 48 bits, so a count that matches only the low word raises no event.
- R3: At a tick where the count equals the slow-domain alarm and did not equal it at the previous tick, raw bit 0 is set. At a tick where the count stops equalling it, raw bit 1 is set.
- R4: Writing 1 to bit 0 or bit 1 of 0x10 sets that enable, and writing 1 to bit 0 or bit 1 of 0x14 clears it. Zero bits leave an enable unchanged. Both addresses read back the current enables in bits 1:0. The slow domain uses the new enables from the next tick onward.
- R5: Offset 0x08 returns the bus-visible raw status in bits 1:0. Offset 0x0C returns that raw status ANDed with the enables.
- R6: Writing 1 to bit 0 or bit 1 of 0x0C clears that raw bit at the next tick, and `irq` stays high until that tick. If an event for the same bit occurs at that same tick, the event wins and the bit stays set.
- R7: The bus-visible raw copy ORs in new events at each tick. A clear shows in this copy only after a write with bit 31 set to 0x18. At the next tick that write copies the whole slow-domain status into the bus copy.
- R8: The pending field at 0x18 bits 1:0 has bit 0 for alarm or enable writes and bit 1 for status clears or reload requests. Each bit is set by such a write and returns to 0 at the next tick. A write in the same cycle as a tick stays pending until the following tick.
- R9: `irq` is a registered level output. It equals the OR over both event bits of slow-domain status AND slow-domain enable, and it follows that state one cycle after the tick that changed it.
- R10: A read with `rd_en` high returns `rdata` together with `rvalid` high one cycle later. `rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe marking a slow-domain clock edge |
| count | input | 48 | Running seconds count |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | 1 | Level-high alarm interrupt |

## Verification
A status clear and a new event for the same bit can land on the same tick. The bench provokes this by moving the count onto the alarm while a clear of bit 0 is still pending. It then judges the outcome by `irq` staying high and the reloaded raw status keeping bit 0. A bus write can also coincide with the tick itself. The bench issues an alarm write with the strobe high and expects the pending field to remain set afterwards, with the old alarm still in use for that tick's compare.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/100ps
package alarm_irq_pkg;
  // event bit positions
  localparam int unsigned EVT_ARRIVE = 0;
  localparam int unsigned EVT_LEAVE  = 1;
  localparam int unsigned NUM_EVT    = 2;

  // register byte offsets
  localparam logic [4:0] OFS_ALM_LO = 5'h00;
  localparam logic [4:0] OFS_ALM_HI = 5'h04;
  localparam logic [4:0] OFS_RAW    = 5'h08;
  localparam logic [4:0] OFS_STS    = 5'h0C;
  localparam logic [4:0] OFS_EN_SET = 5'h10;
  localparam logic [4:0] OFS_EN_CLR = 5'h14;
  localparam logic [4:0] OFS_SYNC   = 5'h18;

  localparam int unsigned RELOAD_BIT = 31;

  // pending field bit positions
  localparam int unsigned PEND_CFG = 0;
  localparam int unsigned PEND_STS = 1;
  localparam int unsigned PEND_W   = 2;
endpackage

// File: rtl/alarm_bus_regs.sv
`timescale 1ns/100ps
module alarm_bus_regs
  import alarm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned EVT_N  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                slow_tick,
  input  logic [EVT_N-1:0]    mirror_raw,
  output logic [CNT_W-1:0]    alarm_b,
  output logic [EVT_N-1:0]    en_b,
  output logic [EVT_N-1:0]    clr_acc,
  output logic                reload_req,
  output logic [PEND_W-1:0]   pend,
  output logic [DATA_W-1:0]   rdata,
  output logic                rvalid
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  logic hit_lo, hit_hi, hit_sts, hit_set, hit_clr, hit_sync;
  logic [EVT_N-1:0] set_mask, clr_mask, sts_mask;
  logic reload_wr, cfg_wr, sts_wr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    hit_lo   = wr_en && (addr == ADDR_W'(OFS_ALM_LO));
    hit_hi   = wr_en && (addr == ADDR_W'(OFS_ALM_HI));
    hit_sts  = wr_en && (addr == ADDR_W'(OFS_STS));
    hit_set  = wr_en && (addr == ADDR_W'(OFS_EN_SET));
    hit_clr  = wr_en && (addr == ADDR_W'(OFS_EN_CLR));
    hit_sync = wr_en && (addr == ADDR_W'(OFS_SYNC));
    set_mask = hit_set ? wdata[EVT_N-1:0] : '0;
    clr_mask = hit_clr ? wdata[EVT_N-1:0] : '0;
    sts_mask = hit_sts ? wdata[EVT_N-1:0] : '0;
    reload_wr = hit_sync && wdata[RELOAD_BIT];
    cfg_wr    = hit_lo || hit_hi || hit_set || hit_clr;
    sts_wr    = hit_sts || reload_wr;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_ALM_LO): rd_mux = alarm_b[DATA_W-1:0];
      ADDR_W'(OFS_ALM_HI): rd_mux = DATA_W'(alarm_b[CNT_W-1:DATA_W]);
      ADDR_W'(OFS_RAW):    rd_mux = DATA_W'(mirror_raw);
      ADDR_W'(OFS_STS):    rd_mux = DATA_W'(mirror_raw & en_b);
      ADDR_W'(OFS_EN_SET): rd_mux = DATA_W'(en_b);
      ADDR_W'(OFS_EN_CLR): rd_mux = DATA_W'(en_b);
      ADDR_W'(OFS_SYNC):   rd_mux = DATA_W'(pend);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_b    <= '1;
      en_b       <= '0;
      clr_acc    <= '0;
      reload_req <= 1'b0;
      pend       <= '0;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      if (hit_lo) alarm_b[DATA_W-1:0] <= wdata;
      if (hit_hi) alarm_b[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      en_b       <= (en_b | set_mask) & ~clr_mask;
      // a tick consumes the staged values seen before this edge
      clr_acc    <= (slow_tick ? '0 : clr_acc) | sts_mask;
      reload_req <= (slow_tick ? 1'b0 : reload_req) | reload_wr;
      pend[PEND_CFG] <= cfg_wr || (pend[PEND_CFG] && !slow_tick);
      pend[PEND_STS] <= sts_wr || (pend[PEND_STS] && !slow_tick);
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/alarm_slow_core.sv
`timescale 1ns/100ps
module alarm_slow_core
  import alarm_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned EVT_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  alarm_b,
  input  logic [EVT_N-1:0]  en_b,
  input  logic [EVT_N-1:0]  clr_acc,
  input  logic              reload_req,
  output logic [EVT_N-1:0]  raw_s,
  output logic [EVT_N-1:0]  en_s,
  output logic [EVT_N-1:0]  mirror
);
  logic [CNT_W-1:0] alarm_s;
  logic             match_q;
  logic             match_now;
  logic [EVT_N-1:0] ev;
  logic [EVT_N-1:0] raw_nxt;

  assign match_now = (count == alarm_s);

  // even-indexed bits fire on arrival at the alarm, odd ones on departure
  for (genvar g = 0; g < EVT_N; g++) begin : g_evt
    if ((g % 2) == EVT_ARRIVE) begin : g_arr
      assign ev[g] = match_now && !match_q;
    end else begin : g_lv
      assign ev[g] = !match_now && match_q;
    end
    // a fresh event outranks a clear applied at the same tick
    assign raw_nxt[g] = (raw_s[g] && !clr_acc[g]) || ev[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_s <= '1;
      en_s    <= '0;
      match_q <= 1'b0;
      raw_s   <= '0;
      mirror  <= '0;
    end else if (slow_tick) begin
      alarm_s <= alarm_b;
      en_s    <= en_b;
      match_q <= match_now;
      raw_s   <= raw_nxt;
      mirror  <= reload_req ? raw_nxt : (mirror | ev);
    end
  end
endmodule

// File: rtl/alarm_irq_out.sv
`timescale 1ns/100ps
module alarm_irq_out #(
  parameter int unsigned EVT_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] raw_s,
  input  logic [EVT_N-1:0] en_s,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw_s & en_s);
  end
endmodule

// File: rtl/alarm_cmp_irq_ctrl.sv
`timescale 1ns/100ps
module alarm_cmp_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              irq
);
  localparam int unsigned EVT_N = NUM_EVT;

  logic [CNT_W-1:0]  alarm_b;
  logic [EVT_N-1:0]  en_b, clr_acc, raw_s, en_s, mirror;
  logic              reload_req;
  logic [PEND_W-1:0] pend;

  alarm_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .EVT_N(EVT_N)
  ) u_bus (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .slow_tick(slow_tick), .mirror_raw(mirror),
    .alarm_b(alarm_b), .en_b(en_b), .clr_acc(clr_acc),
    .reload_req(reload_req), .pend(pend), .rdata(rdata), .rvalid(rvalid)
  );

  alarm_slow_core #(
    .CNT_W(CNT_W), .EVT_N(EVT_N)
  ) u_slow (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .count(count),
    .alarm_b(alarm_b), .en_b(en_b), .clr_acc(clr_acc),
    .reload_req(reload_req), .raw_s(raw_s), .en_s(en_s), .mirror(mirror)
  );

  alarm_irq_out #(
    .EVT_N(EVT_N)
  ) u_irq (
    .clk(clk), .rst(rst), .raw_s(raw_s), .en_s(en_s), .irq(irq)
  );
endmodule

// File: rtl/alarm_cmp_irq_chk.sv
`timescale 1ns/100ps
module alarm_cmp_irq_chk
  import alarm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned EVT_N  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              slow_tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [EVT_N-1:0]  wbits,
  input logic              rvalid,
  input logic              irq,
  input logic [PEND_W-1:0] pend,
  input logic [EVT_N-1:0]  en_s,
  input logic [EVT_N-1:0]  en_b
);
  assert_irq_moves_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq) |-> $past(slow_tick, 2));

  assert_pend_drains_R8: assert property (@(posedge clk) disable iff (rst)
    (slow_tick && !wr_en) |=> (pend == '0));

  assert_read_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  assert_no_stray_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (en_s == '0) |=> !irq);

  assert_enable_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_EN_SET) && wbits[0]) |=> en_b[0]);

  assert_enable_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_EN_CLR) && wbits[0]) |=> !en_b[0]);
endmodule

bind alarm_cmp_irq_ctrl alarm_cmp_irq_chk #(
  .ADDR_W(ADDR_W), .EVT_N(EVT_N)
) u_chk (
  .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
  .rd_en(rd_en), .addr(addr), .wbits(wdata[EVT_N-1:0]), .rvalid(rvalid),
  .irq(irq), .pend(pend), .en_s(en_s), .en_b(en_b)
);

// File: tb/tb_alarm_cmp_irq_ctrl.sv
`timescale 1ns/100ps
module tb_alarm_cmp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic [47:0] count = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  alarm_cmp_irq_ctrl dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .count(count),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      checks++;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL R10: rvalid without a read, rdata=%h expected no data", rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rdata !== e.val) begin
          failures++;
          $display("FAIL %s: rdata=%h expected %h", e.tag, rdata, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; slow_tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; slow_tick = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp_v, input string tag);
    exp_t e;
    @(negedge clk);
    e.val = exp_v; e.tag = tag;
    sb_q.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp_v, input string tag);
    checks++;
    if (irq !== exp_v) begin
      failures++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(5'h00, 32'hFFFF_FFFF, "R1 alarm low reset");
    rd(5'h04, 32'h0000_FFFF, "R1 alarm high reset");
    rd(5'h08, 32'h0, "R1 raw reset");
    rd(5'h0C, 32'h0, "R1 status reset");
    rd(5'h10, 32'h0, "R1 enable reset");
    rd(5'h18, 32'h0, "R1 pending reset");

    // R2 alarm programming, R8 pending
    wr(5'h00, 32'd100);
    wr(5'h04, 32'hFFFF_0000);
    rd(5'h04, 32'h0, "R2 high word keeps 16 bits");
    rd(5'h18, 32'h1, "R8 config pending");
    tick();
    rd(5'h18, 32'h0, "R8 pending drained");

    // R4 enable set
    wr(5'h10, 32'h1);
    rd(5'h10, 32'h1, "R4 enable set readback");
    rd(5'h14, 32'h1, "R4 enable clear address reads enables");
    tick();

    // R3 arrival event
    count = 48'd99; tick();
    chk_irq(1'b0, "R3 no event before alarm");
    count = 48'd100; tick();
    chk_irq(1'b1, "R3 R9 arrival raises irq");
    rd(5'h08, 32'h1, "R3 raw arrival bit");
    // R3 departure event, R5 masking
    count = 48'd101; tick();
    rd(5'h08, 32'h3, "R3 raw departure bit");
    rd(5'h0C, 32'h1, "R5 masked status hides disabled bit");

    // R6 clear waits for tick
    wr(5'h0C, 32'h1);
    rd(5'h18, 32'h2, "R8 status pending");
    chk_irq(1'b1, "R6 irq held until tick");
    tick();
    chk_irq(1'b0, "R6 irq drops at tick");
    rd(5'h08, 32'h3, "R7 bus copy stale before reload");
    wr(5'h18, 32'h8000_0000);
    tick();
    rd(5'h08, 32'h2, "R7 reload refreshes bus copy");
    rd(5'h0C, 32'h0, "R5 masked after clear");

    // R4 second enable and clear
    wr(5'h10, 32'h2);
    tick();
    chk_irq(1'b1, "R4 R9 enabling departure bit raises irq");
    wr(5'h14, 32'h2);
    rd(5'h10, 32'h1, "R4 enable clear readback");
    chk_irq(1'b1, "R4 enable clear waits for tick");
    tick();
    chk_irq(1'b0, "R4 irq off after enable clear");
    wr(5'h14, 32'h0);
    rd(5'h10, 32'h1, "R4 zero write leaves enables");

    // R6 collision: clear and arrival on the same tick
    count = 48'd100;
    wr(5'h0C, 32'h1);
    tick();
    chk_irq(1'b1, "R6 event wins over clear");
    wr(5'h18, 32'h8000_0000);
    tick();
    rd(5'h08, 32'h3, "R6 R7 raw keeps arrival bit");

    // clear everything with reload
    wr(5'h0C, 32'h3);
    wr(5'h18, 32'h8000_0000);
    tick();
    chk_irq(1'b0, "R6 full clear");
    rd(5'h08, 32'h0, "R7 reload after full clear");

    // R8 write coinciding with a tick stays pending
    wr(5'h04, 32'h1, 1);
    rd(5'h18, 32'h1, "R8 write on tick stays pending");
    wr(5'h00, 32'd5);
    tick();
    rd(5'h18, 32'h0, "R8 drained after next tick");

    // R2 all 48 bits compared
    count = 48'd5; tick();
    chk_irq(1'b0, "R2 low-word-only match gives no arrival");
    count = 48'h1_0000_0005; tick();
    chk_irq(1'b1, "R2 full 48-bit match raises irq");
    rd(5'h08, 32'h3, "R2 R3 raw after both events");
    rd(5'h04, 32'h1, "R2 alarm high readback");
    rd(5'h00, 32'd5, "R2 alarm low readback");

    repeat (4) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R10: %0d reads unanswered, expected 0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule